// File: doc/BRIEF.md
# Single-Cycle Stream Bitfield Extractor

This execution unit sits beside a processor ALU. In a single clock it pulls a field of arbitrary length out of a 32-bit window of a bitstream. The window is loaded big-endian, so the first stream bit is the most significant bit of the word. A second operand is a packed descriptor that holds the starting bit offset and the field length.

The field is taken most-significant-bit first. The word is shifted left by the offset, which drops the bits ahead of the field. It is then shifted right so the field lands right-justified with zeros above it. Because of this, the result does not depend on the host's byte order.

The caller splits a global stream position into a byte index and a bit offset (position AND 7). It supplies only that bit offset as the location. One operation can be accepted every cycle. Each result is registered and stays valid until the next accepted operation replaces it.

Top module: `bitfield_extract`

## Requirements
- R1: With `issue_i` high at a rising edge, `valid_o` is high after that edge; with `issue_i` low, `valid_o` is low after it, so back-to-back operations each produce one result one cycle later.
- R2: The descriptor holds the size in bits [5:0] and the location in bits [12:8]; every other descriptor bit has no effect on the result or flag.
- R3: Stream bit k is word bit 31-k; for location L and size S with L+S <= 32 the result equals word bits [31-L : 32-L-S] placed in result bits [S-1:0].
- R4: All result bits at and above the number of bits returned are zero.
- R5: A size of 0 returns a result of 0 and clears `ovf_o`.
- R6: When L+S > 32 (with S limited as in R7), only word bits [31-L : 0] are returned, right-justified, and `ovf_o` is 1; otherwise `ovf_o` is 0.
- R7: Size values 33 to 63 act as 32.
- R8: While `issue_i` is low, `result_o` and `ovf_o` keep their values.
- R9: After reset `valid_o`, `ovf_o` and `result_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Accept an operation this cycle |
| word_i | input | 32 | Bitstream window, first stream bit in the MSB |
| desc_i | input | 32 | Packed descriptor: size [5:0], location [12:8] |
| result_o | output | 32 | Right-justified extracted field |
| valid_o | output | 1 | Result produced by the previous cycle's operation |
| ovf_o | output | 1 | Requested field ran past the end of the word |

## Verification
The bench builds the unit with its default parameters: a 32-bit word and the location field starting at descriptor bit 8. This reaches every location from 0 to 31 and every size code from 0 to 63. The bench sweeps all locations at several sizes, against a model that gathers the field one bit at a time. That sweep reaches the exact-fit edge, where location plus size equals 32, and the one-bit-over edge with the overflow flag. The saturating size codes, the ignored descriptor bits and back-to-back issue are each driven on purpose.

// File: rtl/bitfield_extract.sv
module bitfield_extract #(
  parameter int WORD_W  = 32,
  parameter int LOC_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] desc_i,
  output logic [WORD_W-1:0] result_o,
  output logic              valid_o,
  output logic              ovf_o
);
  localparam int LOC_W  = $clog2(WORD_W);
  localparam int SIZE_W = LOC_W + 1;
  localparam logic [SIZE_W-1:0] FULL = SIZE_W'(WORD_W);

  logic [LOC_W-1:0]  loc;
  logic [SIZE_W-1:0] size_raw, size_eff, avail, take, rshift;
  logic [WORD_W-1:0] shifted, field;
  logic              over;

  assign loc      = desc_i[LOC_LSB +: LOC_W];
  assign size_raw = desc_i[SIZE_W-1:0];
  assign size_eff = (size_raw > FULL) ? FULL : size_raw;
  assign avail    = FULL - {1'b0, loc};
  assign over     = size_eff > avail;
  assign take     = over ? avail : size_eff;
  assign rshift   = FULL - take;
  assign shifted  = word_i << loc;
  assign field    = (take == '0) ? '0 : (shifted >> rshift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      ovf_o    <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= issue_i;
      if (issue_i) begin
        result_o <= field;
        ovf_o    <= over;
      end
    end
  end
endmodule

// File: rtl/bitfield_extract_chk.sv
module bitfield_extract_chk #(
  parameter int WORD_W  = 32,
  parameter int LOC_LSB = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_i,
  input logic [WORD_W-1:0] word_i,
  input logic [WORD_W-1:0] desc_i,
  input logic [WORD_W-1:0] result_o,
  input logic              valid_o,
  input logic              ovf_o
);
  localparam int LOC_W  = $clog2(WORD_W);
  localparam int SIZE_W = LOC_W + 1;

  logic [LOC_W-1:0]  c_loc;
  logic [SIZE_W-1:0] c_size;
  assign c_loc  = desc_i[LOC_LSB +: LOC_W];
  assign c_size = desc_i[SIZE_W-1:0];

  // R1
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> valid_o);
  // R1
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !valid_o);
  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(result_o) && $stable(ovf_o)));
  // R5
  zero_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && c_size == '0) |=> (result_o == '0 && !ovf_o));
  // R7
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && c_loc == '0 && c_size >= SIZE_W'(WORD_W)) |=> (result_o == $past(word_i) && !ovf_o));
  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && (32'(c_loc) + 32'(c_size)) <= 32'(WORD_W)) |=> !ovf_o);
  // R4
  top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && c_size == SIZE_W'(1)) |=> (result_o[WORD_W-1:1] == '0));
endmodule

bind bitfield_extract bitfield_extract_chk #(.WORD_W(WORD_W), .LOC_LSB(LOC_LSB)) chk_i (.*);

// File: tb/bitfield_extract_test.sv
module bitfield_extract_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [31:0] word_i = '0;
  logic [31:0] desc_i = '0;
  logic [31:0] result_o;
  logic        valid_o;
  logic        ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  bitfield_extract uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .word_i(word_i),
    .desc_i(desc_i), .result_o(result_o), .valid_o(valid_o), .ovf_o(ovf_o)
  );

  function automatic logic [31:0] mk_desc(int loc, int size);
    return (32'(loc) << 8) + 32'(size);
  endfunction

  function automatic logic [32:0] model(logic [31:0] w, int loc, int size);
    logic [31:0] r = '0;
    int s = (size > 32) ? 32 : size;
    int n = 0;
    bit ov = (loc + s) > 32;
    for (int i = 0; i < s; i++) begin
      if (31 - loc - i >= 0) begin
        r = {r[30:0], w[31-loc-i]};
        n++;
      end
    end
    return {ov, r};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(logic [31:0] w, logic [31:0] d, string req);
    logic [32:0] e;
    e = model(w, int'(d[12:8]), int'(d[5:0]));
    @(negedge clk);
    issue_i = 1'b1; word_i = w; desc_i = d;
    @(negedge clk);
    issue_i = 1'b0;
    check({req, " result"}, result_o, e[31:0]);
    check({req, " ovf"}, {31'b0, ovf_o}, {31'b0, e[32]});
    check({req, " valid"}, {31'b0, valid_o}, 32'd1);
  endtask

  task automatic t_reset();
    check("R9 valid", {31'b0, valid_o}, 0);
    check("R9 ovf", {31'b0, ovf_o}, 0);
    check("R9 result", result_o, 0);
  endtask

  task automatic t_basic();
    run_op(32'hF0E1_D2C3, mk_desc(0, 8), "R3 head byte");
    run_op(32'hF0E1_D2C3, mk_desc(4, 8), "R3 mid byte");
    run_op(32'h7F08_0000, mk_desc(3, 5), "R3 R4 small field");
    run_op(32'h8000_0001, mk_desc(31, 1), "R3 last bit");
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    issue_i = 1'b1; word_i = 32'hABCD_1234; desc_i = mk_desc(8, 8);
    @(negedge clk);
    check("R1 first result", result_o, 32'h0000_00CD);
    check("R1 first valid", {31'b0, valid_o}, 1);
    word_i = 32'h1234_5678; desc_i = mk_desc(16, 12);
    @(negedge clk);
    issue_i = 1'b0;
    check("R1 second result", result_o, 32'h0000_0567);
    check("R1 second valid", {31'b0, valid_o}, 1);
    @(negedge clk);
    check("R1 idle valid", {31'b0, valid_o}, 0);
  endtask

  task automatic t_zero_size();
    run_op(32'hFFFF_FFFF, mk_desc(5, 0), "R5 zero size");
  endtask

  task automatic t_overflow();
    run_op(32'hFFFF_FFFF, mk_desc(28, 8), "R6 past end");
    run_op(32'h0000_00A5, mk_desc(24, 9), "R6 one over");
    run_op(32'h0000_00A5, mk_desc(24, 8), "R6 exact fit");
  endtask

  task automatic t_oversize();
    run_op(32'hDEAD_BEEF, mk_desc(0, 63), "R7 code 63");
    run_op(32'hDEAD_BEEF, mk_desc(0, 33), "R7 code 33");
    run_op(32'hDEAD_BEEF, mk_desc(4, 40), "R7 R6 code 40");
  endtask

  task automatic t_ignored();
    run_op(32'hC3A5_0F96, 32'hFFFF_E0C0 | mk_desc(6, 10), "R2 junk bits");
    check("R2 vs clean", result_o, model(32'hC3A5_0F96, 6, 10));
  endtask

  task automatic t_hold();
    logic [31:0] r0;
    logic        o0;
    run_op(32'hFFFF_FFFF, mk_desc(30, 4), "R8 setup");
    r0 = result_o; o0 = ovf_o;
    word_i = 32'h1111_1111; desc_i = mk_desc(0, 32);
    repeat (3) @(negedge clk);
    check("R8 result held", result_o, r0);
    check("R8 ovf held", {31'b0, ovf_o}, {31'b0, o0});
  endtask

  task automatic t_sweep();
    int sizes[4] = '{1, 7, 16, 32};
    foreach (sizes[j])
      for (int l = 0; l < 32; l++)
        run_op(32'h9B3C_6E15 ^ (32'(l) * 32'h0101_0101), mk_desc(l, sizes[j]), "R3 R4 R6 sweep");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_back_to_back();
    t_zero_size();
    t_overflow();
    t_oversize();
    t_ignored();
    t_hold();
    t_sweep();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule